// File: doc/BRIEF.md
# DRAM Write Command Timing Scheduler

This block sits on the controller side of a DRAM interface. It takes one stream of command requests (WRITE, READ and PRECHARGE) and decides, cycle by cycle, whether the request at the head of the stream may go onto the command bus yet. A WRITE carries a bank, a starting column and an auto-precharge flag. A READ and a PRECHARGE carry a bank. A request that would break a write-related spacing rule is stalled, never dropped. Because there is a single request channel, requests always issue in the order they arrive.

The block keeps timers for several rules. Consecutive writes are spaced at half the burst length. Reads must wait for the write-to-read turnaround, counted from the last data beat of the latest write. A PRECHARGE must wait for write recovery on its bank, and for the minimum row active time counted from an activate notice supplied by the row scheduler. After a precharge, the bank stays idle for the precharge period. When a write asks for auto precharge, the bank closes internally at the earliest point where both write recovery and the minimum row active time are met, and the bank then stays blocked for the precharge period. The data of a write burst therefore can never be cut short by a later command.

A grant in cycle t puts the command on the registered bus in cycle t+1, which is the issue cycle. All timing parameters are counted in clock cycles.

Top module: `wr_cmd_sched`

## Requirements
- R1: A granted WRITE drives CS# low, RAS# high, CAS# low and WE# low, with the bank on `baOut`. Column bits below bit 8 go to the same address bits. Column bits 8 and above go one position higher. Address bit 8 carries the auto-precharge flag (1 = close the row after the burst).
- R2: A granted READ drives CS# low, RAS# high, CAS# low, WE# high, with the column mapped as in R1 and address bit 8 forced low whatever `reqAutoPre` is. A granted PRECHARGE drives CS# low, RAS# low, CAS# high, WE# low, with the bank on `baOut` and an all-zero address.
- R3: `reqGrant` is high only while `reqValid` is high. A request granted in cycle t appears on the bus in cycle t+1. A cycle with no grant is followed by a deselect cycle: all four strobes high, bank and address zero. Request kinds are encoded 00 = WRITE, 01 = READ, 10 = PRECHARGE.
- R4: Two WRITE issue cycles are at least BL/2 cycles apart.
- R5: A READ to any bank issues no earlier than WL + BL/2 + T_WTR cycles after the latest WRITE issue. This is T_WTR cycles past the cycle after the last data beat.
- R6: A PRECHARGE to a bank issues no earlier than WL + BL/2 + T_WR cycles after the latest WRITE issue to that bank, so no burst is truncated.
- R7: A PRECHARGE to a bank issues no earlier than T_RAS cycles after the cycle in which `actFire` was high for that bank.
- R8: After a PRECHARGE issues to a bank in cycle p, no command to that bank issues before p + T_RP. Other banks are not held.
- R9: A WRITE issued in cycle c with auto precharge closes its bank internally at P = max(c + WL + BL/2 + T_WR, activate + T_RAS), without a bus command. No command to that bank issues before P + T_RP.
- R10: During reset and on its release, the bus is deselected and every timer is clear, so a first request is granted in the first cycle it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| reqValid | input | 1 | A request is presented; it is held until granted |
| reqKind | input | 2 | Request kind: 00 WRITE, 01 READ, 10 PRECHARGE |
| reqBank | input | BANK_W | Target bank |
| reqCol | input | COL_W | Starting column (WRITE and READ) |
| reqAutoPre | input | 1 | Auto-precharge flag (WRITE only) |
| reqGrant | output | 1 | High in the cycle the head request is accepted |
| actFire | input | 1 | Activate issued by the row scheduler in this cycle |
| actBank | input | BANK_W | Bank of that activate |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| baOut | output | BANK_W | Bank address |
| addrOut | output | ADDR_W | Address lines; bit 8 is the auto-precharge flag |

## Verification
The bound checker watches, on every cycle and at the pins, the command encodings and the grant-to-issue relation. It also checks the write-to-write spacing, the write-to-read turnaround, write recovery before an explicit precharge, and the precharge period after an explicit precharge. The internal closing of a bank by auto precharge puts nothing on the bus, so only the bench scenarios show it. Those scenarios also show the choice between write recovery and row active time as the binding limit, and the in-order stalling behind a blocked request. The bench reference model works out each legal issue cycle from timestamps and compares the bus and the grant every cycle.

// File: rtl/wcs_pkg.sv
package wcs_pkg;

  // Request kinds on the single in-order request channel
  typedef enum logic [1:0] {
    KIND_WR  = 2'b00,
    KIND_RD  = 2'b01,
    KIND_PRE = 2'b10
  } req_kind_e;

  // Strobes from control to the command-bus datapath
  typedef struct packed {
    logic issueWr;
    logic issueRd;
    logic issuePre;
    logic autoPre;
  } cmd_strobe_t;

endpackage

// File: rtl/wcs_timer.sv
// Loadable down-counter; zero means the guarded rule is satisfied.
module wcs_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         load,
  input  logic [W-1:0] loadVal,
  output logic         isZero
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= loadVal;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign isZero = (cnt == '0);

endmodule

// File: rtl/wcs_ctrl.sv
// Legality decision and timer bookkeeping for the head request.
module wcs_ctrl
  import wcs_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2,
  parameter int BL        = 8,
  parameter int WL        = 3,
  parameter int T_WTR     = 2,
  parameter int T_WR      = 3,
  parameter int T_RP      = 3,
  parameter int T_RAS     = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqKind,
  input  logic [BANK_W-1:0] reqBank,
  input  logic              reqAutoPre,
  input  logic              actFire,
  input  logic [BANK_W-1:0] actBank,
  output logic              reqGrant,
  output cmd_strobe_t       strobe
);

  // Spacings expressed relative to the grant of a WRITE
  localparam int GAP   = BL / 2;
  localparam int N_RD  = WL + GAP + T_WTR;
  localparam int N_WR  = WL + GAP + T_WR;
  localparam int MAX_A = (N_RD > N_WR) ? N_RD : N_WR;
  localparam int MAX_B = (T_RP > T_RAS) ? T_RP : T_RAS;
  localparam int MAXN  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W = $clog2(MAXN + 1);

  logic wantWr, wantRd, wantPre;
  logic grantWr, grantRd, grantPre;
  logic gapZero, wtrZero;
  logic selBusy;

  logic [NUM_BANKS-1:0] wrRecZero;
  logic [NUM_BANKS-1:0] rasZero;
  logic [NUM_BANKS-1:0] rpZero;
  logic [NUM_BANKS-1:0] apPend;
  logic [NUM_BANKS-1:0] apFire;
  logic [NUM_BANKS-1:0] bankBusy;
  logic [NUM_BANKS-1:0] wrHit;
  logic [NUM_BANKS-1:0] preHit;
  logic [NUM_BANKS-1:0] actHit;

  assign wantWr  = reqValid && (reqKind == KIND_WR);
  assign wantRd  = reqValid && (reqKind == KIND_RD);
  assign wantPre = reqValid && (reqKind == KIND_PRE);

  assign selBusy  = bankBusy[reqBank];
  assign grantWr  = wantWr  && gapZero && !selBusy;
  assign grantRd  = wantRd  && wtrZero && !selBusy;
  assign grantPre = wantPre && wrRecZero[reqBank] && rasZero[reqBank] && !selBusy;

  assign reqGrant = grantWr || grantRd || grantPre;

  always_comb begin
    strobe.issueWr  = grantWr;
    strobe.issueRd  = grantRd;
    strobe.issuePre = grantPre;
    strobe.autoPre  = grantWr && reqAutoPre;
  end

  // Device-wide write-to-write spacing
  wcs_timer #(.W(CNT_W)) i_gap (
    .clk     (clk),
    .rstN    (rstN),
    .load    (grantWr),
    .loadVal (CNT_W'(GAP - 1)),
    .isZero  (gapZero)
  );

  // Device-wide write-to-read turnaround
  wcs_timer #(.W(CNT_W)) i_wtr (
    .clk     (clk),
    .rstN    (rstN),
    .load    (grantWr),
    .loadVal (CNT_W'(N_RD - 1)),
    .isZero  (wtrZero)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign wrHit[b]  = grantWr  && (reqBank == BANK_W'(b));
    assign preHit[b] = grantPre && (reqBank == BANK_W'(b));
    assign actHit[b] = actFire  && (actBank == BANK_W'(b));

    // Write recovery: burst data plus T_WR
    wcs_timer #(.W(CNT_W)) i_wrRec (
      .clk     (clk),
      .rstN    (rstN),
      .load    (wrHit[b]),
      .loadVal (CNT_W'(N_WR - 1)),
      .isZero  (wrRecZero[b])
    );

    // Minimum row active time from the activate notice
    wcs_timer #(.W(CNT_W)) i_ras (
      .clk     (clk),
      .rstN    (rstN),
      .load    (actHit[b]),
      .loadVal (CNT_W'(T_RAS - 2)),
      .isZero  (rasZero[b])
    );

    // Precharge period after an explicit or internal close
    wcs_timer #(.W(CNT_W)) i_rp (
      .clk     (clk),
      .rstN    (rstN),
      .load    (preHit[b] || apFire[b]),
      .loadVal (CNT_W'(T_RP - 1)),
      .isZero  (rpZero[b])
    );

    // Auto precharge waits for both recovery and row active time
    always_ff @(posedge clk) begin
      if (!rstN) begin
        apPend[b] <= 1'b0;
      end else if (wrHit[b] && reqAutoPre) begin
        apPend[b] <= 1'b1;
      end else if (apFire[b]) begin
        apPend[b] <= 1'b0;
      end
    end

    assign apFire[b]   = apPend[b] && wrRecZero[b] && rasZero[b];
    assign bankBusy[b] = apPend[b] || !rpZero[b];
  end

endmodule

// File: rtl/wcs_datapath.sv
// Registered command bus built from control strobes.
module wcs_datapath
  import wcs_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ADDR_W = 12,
  parameter int COL_W  = 9,
  parameter int AP_BIT = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  cmd_strobe_t       strobe,
  input  logic [BANK_W-1:0] reqBank,
  input  logic [COL_W-1:0]  reqCol,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [BANK_W-1:0] baOut,
  output logic [ADDR_W-1:0] addrOut
);

  logic [ADDR_W-1:0] colMapped;
  logic              csNxt, rasNxt, casNxt, weNxt;
  logic [BANK_W-1:0] baNxt;
  logic [ADDR_W-1:0] addrNxt;

  // Column bits skip over the auto-precharge position
  always_comb begin
    colMapped = '0;
    for (int i = 0; i < COL_W; i++) begin
      if (i < AP_BIT) colMapped[i] = reqCol[i];
      else            colMapped[i + 1] = reqCol[i];
    end
  end

  always_comb begin
    csNxt   = 1'b1;
    rasNxt  = 1'b1;
    casNxt  = 1'b1;
    weNxt   = 1'b1;
    baNxt   = '0;
    addrNxt = '0;
    if (strobe.issueWr) begin
      csNxt           = 1'b0;
      casNxt          = 1'b0;
      weNxt           = 1'b0;
      baNxt           = reqBank;
      addrNxt         = colMapped;
      addrNxt[AP_BIT] = strobe.autoPre;
    end else if (strobe.issueRd) begin
      csNxt   = 1'b0;
      casNxt  = 1'b0;
      baNxt   = reqBank;
      addrNxt = colMapped;
    end else if (strobe.issuePre) begin
      csNxt  = 1'b0;
      rasNxt = 1'b0;
      weNxt  = 1'b0;
      baNxt  = reqBank;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csN     <= 1'b1;
      rasN    <= 1'b1;
      casN    <= 1'b1;
      weN     <= 1'b1;
      baOut   <= '0;
      addrOut <= '0;
    end else begin
      csN     <= csNxt;
      rasN    <= rasNxt;
      casN    <= casNxt;
      weN     <= weNxt;
      baOut   <= baNxt;
      addrOut <= addrNxt;
    end
  end

endmodule

// File: rtl/wr_cmd_sched.sv
// Top: write-related command timing scheduler.
module wr_cmd_sched
  import wcs_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 12,
  parameter int COL_W     = 9,
  parameter int AP_BIT    = 8,
  parameter int BL        = 8,
  parameter int WL        = 3,
  parameter int T_WTR     = 2,
  parameter int T_WR      = 3,
  parameter int T_RP      = 3,
  parameter int T_RAS     = 14,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqKind,
  input  logic [BANK_W-1:0] reqBank,
  input  logic [COL_W-1:0]  reqCol,
  input  logic              reqAutoPre,
  output logic              reqGrant,
  input  logic              actFire,
  input  logic [BANK_W-1:0] actBank,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [BANK_W-1:0] baOut,
  output logic [ADDR_W-1:0] addrOut
);

  cmd_strobe_t strobe;

  wcs_ctrl #(
    .NUM_BANKS (NUM_BANKS),
    .BANK_W    (BANK_W),
    .BL        (BL),
    .WL        (WL),
    .T_WTR     (T_WTR),
    .T_WR      (T_WR),
    .T_RP      (T_RP),
    .T_RAS     (T_RAS)
  ) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqKind    (reqKind),
    .reqBank    (reqBank),
    .reqAutoPre (reqAutoPre),
    .actFire    (actFire),
    .actBank    (actBank),
    .reqGrant   (reqGrant),
    .strobe     (strobe)
  );

  wcs_datapath #(
    .BANK_W (BANK_W),
    .ADDR_W (ADDR_W),
    .COL_W  (COL_W),
    .AP_BIT (AP_BIT)
  ) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .reqBank (reqBank),
    .reqCol  (reqCol),
    .csN     (csN),
    .rasN    (rasN),
    .casN    (casN),
    .weN     (weN),
    .baOut   (baOut),
    .addrOut (addrOut)
  );

endmodule

// File: rtl/wr_cmd_sched_chk.sv
// Pin-level timing checker bound to the scheduler top.
module wr_cmd_sched_chk #(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 12,
  parameter int AP_BIT    = 8,
  parameter int BL        = 8,
  parameter int WL        = 3,
  parameter int T_WTR     = 2,
  parameter int T_WR      = 3,
  parameter int T_RP      = 3,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqAutoPre,
  input logic              reqGrant,
  input logic              csN,
  input logic              rasN,
  input logic              casN,
  input logic              weN,
  input logic [BANK_W-1:0] baOut,
  input logic [ADDR_W-1:0] addrOut
);

  localparam int GAP  = BL / 2;
  localparam int N_RD = WL + GAP + T_WTR;
  localparam int N_WR = WL + GAP + T_WR;
  localparam int CW   = $clog2(N_RD + N_WR + T_RP + GAP) + 1;

  logic isWr, isRd, isPre;
  assign isWr  = !csN &&  rasN && !casN && !weN;
  assign isRd  = !csN &&  rasN && !casN &&  weN;
  assign isPre = !csN && !rasN &&  casN && !weN;

  logic [CW-1:0] sinceWr;
  logic [CW-1:0] sinceWrB  [NUM_BANKS];
  logic [CW-1:0] sincePreB [NUM_BANKS];

  always_ff @(posedge clk) begin
    if (!rstN)                sinceWr <= '1;
    else if (isWr)            sinceWr <= CW'(1);
    else if (sinceWr != '1)   sinceWr <= sinceWr + 1'b1;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rstN)                                sinceWrB[b] <= '1;
      else if (isWr && baOut == BANK_W'(b))     sinceWrB[b] <= CW'(1);
      else if (sinceWrB[b] != '1)               sinceWrB[b] <= sinceWrB[b] + 1'b1;
    end
    always_ff @(posedge clk) begin
      if (!rstN)                                sincePreB[b] <= '1;
      else if (isPre && baOut == BANK_W'(b))    sincePreB[b] <= CW'(1);
      else if (sincePreB[b] != '1)              sincePreB[b] <= sincePreB[b] + 1'b1;
    end
  end

  a_r1_ap_bit_follows_req: assert property (@(posedge clk) disable iff (!rstN)
    isWr |-> (addrOut[AP_BIT] == $past(reqAutoPre)));

  a_r2_read_no_ap: assert property (@(posedge clk) disable iff (!rstN)
    isRd |-> !addrOut[AP_BIT]);

  a_r3_grant_needs_valid: assert property (@(posedge clk) disable iff (!rstN)
    reqGrant |-> reqValid);

  a_r3_grant_issues_next: assert property (@(posedge clk) disable iff (!rstN)
    reqGrant |=> !csN);

  a_r3_idle_deselect: assert property (@(posedge clk) disable iff (!rstN)
    !reqGrant |=> (csN && rasN && casN && weN));

  a_r4_write_spacing: assert property (@(posedge clk) disable iff (!rstN)
    isWr |-> (sinceWr >= CW'(GAP)));

  a_r5_write_to_read: assert property (@(posedge clk) disable iff (!rstN)
    isRd |-> (sinceWr >= CW'(N_RD)));

  a_r6_recovery_before_pre: assert property (@(posedge clk) disable iff (!rstN)
    isPre |-> (sinceWrB[baOut] >= CW'(N_WR)));

  a_r8_precharge_period: assert property (@(posedge clk) disable iff (!rstN)
    !csN |-> (sincePreB[baOut] >= CW'(T_RP)));

endmodule

bind wr_cmd_sched wr_cmd_sched_chk #(
  .NUM_BANKS (NUM_BANKS),
  .ADDR_W    (ADDR_W),
  .AP_BIT    (AP_BIT),
  .BL        (BL),
  .WL        (WL),
  .T_WTR     (T_WTR),
  .T_WR      (T_WR),
  .T_RP      (T_RP)
) i_wr_cmd_sched_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqAutoPre (reqAutoPre),
  .reqGrant   (reqGrant),
  .csN        (csN),
  .rasN       (rasN),
  .casN       (casN),
  .weN        (weN),
  .baOut      (baOut),
  .addrOut    (addrOut)
);

// File: tb/test_wr_cmd_sched.sv
module test_wr_cmd_sched;

  localparam int CLK_PERIOD = 10;
  localparam int NB     = 4;
  localparam int BW     = 2;
  localparam int ADDR_W = 12;
  localparam int COL_W  = 9;
  localparam int AP_BIT = 8;
  localparam int BL     = 8;
  localparam int WL     = 3;
  localparam int T_WTR  = 2;
  localparam int T_WR   = 3;
  localparam int T_RP   = 3;
  localparam int T_RAS  = 14;
  localparam int GAP    = BL / 2;
  localparam int N_RD   = WL + GAP + T_WTR;
  localparam int N_WR   = WL + GAP + T_WR;

  localparam int K_WR = 0, K_RD = 1, K_PRE = 2, K_ACT = 3, K_IDLE = 4;

  logic              clk = 1'b0;
  logic              rstN;
  logic              reqValid;
  logic [1:0]        reqKind;
  logic [BW-1:0]     reqBank;
  logic [COL_W-1:0]  reqCol;
  logic              reqAutoPre;
  logic              reqGrant;
  logic              actFire;
  logic [BW-1:0]     actBank;
  logic              csN, rasN, casN, weN;
  logic [BW-1:0]     baOut;
  logic [ADDR_W-1:0] addrOut;

  wr_cmd_sched #(
    .NUM_BANKS (NB), .ADDR_W (ADDR_W), .COL_W (COL_W), .AP_BIT (AP_BIT),
    .BL (BL), .WL (WL), .T_WTR (T_WTR), .T_WR (T_WR), .T_RP (T_RP), .T_RAS (T_RAS)
  ) i_wr_cmd_sched (
    .clk (clk), .rstN (rstN), .reqValid (reqValid), .reqKind (reqKind),
    .reqBank (reqBank), .reqCol (reqCol), .reqAutoPre (reqAutoPre),
    .reqGrant (reqGrant), .actFire (actFire), .actBank (actBank),
    .csN (csN), .rasN (rasN), .casN (casN), .weN (weN),
    .baOut (baOut), .addrOut (addrOut)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  typedef struct {
    int kind;
    int bank;
    int col;
    bit ap;
  } item_t;

  item_t q[$];
  int nChecks = 0;
  int nFails  = 0;

  // Reference model state, all in issue-cycle timestamps
  int    lastWr;
  int    lastWrB  [NB];
  int    lastAct  [NB];
  int    bankFree [NB];
  string freeTag  [NB];

  // Expected bus for the current cycle and the next one
  logic [3:0]        expStr, nxtStr;
  logic [BW-1:0]     expBa, nxtBa;
  logic [ADDR_W-1:0] expAddr, nxtAddr;
  string             expTag, nxtTag;

  task automatic push(int k, int b, int c, bit ap);
    item_t it;
    it.kind = k; it.bank = b; it.col = c; it.ap = ap;
    q.push_back(it);
  endtask

  function automatic logic [ADDR_W-1:0] mapCol(int c);
    int lo, hi;
    lo = c % (1 << AP_BIT);
    hi = (c / (1 << AP_BIT)) * (1 << (AP_BIT + 1));
    return ADDR_W'(lo + hi);
  endfunction

  task automatic checkBus(int cyc);
    nChecks++;
    if ({csN, rasN, casN, weN} !== expStr || baOut !== expBa || addrOut !== expAddr) begin
      nFails++;
      $display("FAIL %s bus cycle %0d: got strobes %b ba %0d addr %h, expected strobes %b ba %0d addr %h",
               expTag, cyc, {csN, rasN, casN, weN}, baOut, addrOut, expStr, expBa, expAddr);
    end
  endtask

  task automatic checkGrant(int cyc, bit expG, string tag);
    nChecks++;
    if (reqGrant !== expG) begin
      nFails++;
      $display("FAIL %s grant cycle %0d: got %b, expected %b", tag, cyc, reqGrant, expG);
    end
  endtask

  initial begin
    int n;
    int tail;
    int legal;
    int c;
    int pt;
    bit expG;
    string tag;
    item_t h;

    rstN = 1'b0; reqValid = 1'b0; reqKind = '0; reqBank = '0; reqCol = '0;
    reqAutoPre = 1'b0; actFire = 1'b0; actBank = '0;
    lastWr = -1000;
    for (int b = 0; b < NB; b++) begin
      lastWrB[b] = -1000; lastAct[b] = -1000; bankFree[b] = -1000; freeTag[b] = "R8";
    end
    expStr = 4'b1111; expBa = '0; expAddr = '0; expTag = "R10";

    // R10: reset state of the bus and grant
    repeat (2) @(negedge clk);
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      checkBus(-1);
      checkGrant(-1, 1'b0, "R10");
    end

    // Scenarios
    push(K_WR, 0, 'h1A5, 0);   // R10 immediate grant, R1 column mapping
    push(K_WR, 1, 'h033, 0);   // R4 spacing
    push(K_RD, 2, 'h110, 1);   // R5 turnaround, R2 flag ignored
    push(K_ACT, 3, 0, 0);
    push(K_PRE, 3, 0, 0);      // R7 row active time binds
    push(K_WR, 3, 'h100, 0);
    push(K_PRE, 3, 0, 0);      // R6 recovery binds
    push(K_WR, 3, 'h0C3, 0);   // R8 precharge period
    push(K_WR, 1, 'h0FF, 0);
    push(K_ACT, 2, 0, 0);
    push(K_WR, 2, 'h1F0, 1);   // R9 auto precharge, row active time binds
    push(K_RD, 2, 'h002, 0);   // R9 bank blocked
    for (int k = 0; k < 20; k++) push(K_IDLE, 0, 0, 0);
    push(K_ACT, 0, 0, 0);
    for (int k = 0; k < 20; k++) push(K_IDLE, 0, 0, 0);
    push(K_WR, 0, 'h0AA, 1);   // R9 auto precharge, recovery binds
    push(K_PRE, 0, 0, 0);      // R9 explicit precharge waits on closed bank
    push(K_WR, 1, 'h155, 0);
    push(K_PRE, 1, 0, 0);      // R6
    push(K_RD, 1, 'h1FF, 1);   // R8 after precharge, R2

    rstN = 1'b1;
    n = 0;
    tail = 0;
    while (1) begin
      checkBus(n);

      reqValid = 1'b0; actFire = 1'b0;
      nxtStr = 4'b1111; nxtBa = '0; nxtAddr = '0; nxtTag = "R3";
      expG = 1'b0; tag = "R3";
      if (q.size() > 0) begin
        h = q[0];
        if (h.kind == K_IDLE) begin
          void'(q.pop_front());
        end else if (h.kind == K_ACT) begin
          actFire = 1'b1; actBank = BW'(h.bank);
          lastAct[h.bank] = n;
          void'(q.pop_front());
        end else begin
          reqValid   = 1'b1;
          reqKind    = 2'(h.kind);
          reqBank    = BW'(h.bank);
          reqCol     = COL_W'(h.col);
          reqAutoPre = h.ap;
          legal = bankFree[h.bank]; tag = freeTag[h.bank];
          if (h.kind == K_WR && lastWr + GAP > legal) begin
            legal = lastWr + GAP; tag = "R4";
          end
          if (h.kind == K_RD && lastWr + N_RD > legal) begin
            legal = lastWr + N_RD; tag = "R5";
          end
          if (h.kind == K_PRE && lastWrB[h.bank] + N_WR > legal) begin
            legal = lastWrB[h.bank] + N_WR; tag = "R6";
          end
          if (h.kind == K_PRE && lastAct[h.bank] + T_RAS > legal) begin
            legal = lastAct[h.bank] + T_RAS; tag = "R7";
          end
          if (legal <= n + 1) begin
            expG = 1'b1;
            c = n + 1;
            nxtBa = BW'(h.bank);
            if (h.kind == K_WR) begin
              lastWr = c; lastWrB[h.bank] = c;
              nxtStr = 4'b0100;
              nxtAddr = mapCol(h.col);
              nxtAddr[AP_BIT] = h.ap;
              nxtTag = h.ap ? "R9" : "R1";
              if (h.ap) begin
                pt = c + N_WR;
                if (lastAct[h.bank] + T_RAS > pt) pt = lastAct[h.bank] + T_RAS;
                bankFree[h.bank] = pt + T_RP; freeTag[h.bank] = "R9";
              end
            end else if (h.kind == K_RD) begin
              nxtStr = 4'b0101; nxtAddr = mapCol(h.col); nxtTag = "R2";
            end else begin
              nxtStr = 4'b0010; nxtAddr = '0; nxtTag = "R2";
              bankFree[h.bank] = c + T_RP; freeTag[h.bank] = "R8";
            end
            void'(q.pop_front());
          end
        end
      end

      #1;
      checkGrant(n, expG, tag);

      expStr = nxtStr; expBa = nxtBa; expAddr = nxtAddr; expTag = nxtTag;
      if (q.size() == 0) tail++;
      if (tail > 20) break;
      if (n > 4000) begin
        nChecks++; nFails++;
        $display("FAIL R3 watchdog: got %0d cycles, expected at most 4000", n);
        break;
      end
      n++;
      @(negedge clk);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule